// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block takes one write of an interrupt command and turns it into exactly one inter-processor interrupt message on a shared message bus. A command has six fields: a 3-bit delivery mode, an 8-bit vector, a level flag, a trigger flag, a destination processor ID and a 2-bit shorthand. The block checks that the mode is one it may send. It resolves the shorthand and destination into a bitmask of target processors and clears the vector where the mode forbids one. It then offers the message with a valid/ready handshake.

After the bus takes the message, the block waits for one response that either accepts or rejects it. A rejected message is sent again automatically, up to a parameterised limit, except for start-up messages, which are never resent. The mode code 101 covers two commands: with the level flag set it is an INIT request, and with the level flag clear and the trigger flag set it is an INIT de-assert, which goes to every processor. Four sticky status outputs report a command in flight, an illegal mode, a delivery that finally failed, and a command written while one was in flight.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, busy, msgValid, errMode, failed and overrun are all 0.
- R2: Mode 000 (fixed) and mode 110 (start-up) carry the written 8-bit vector unchanged in msgVector.
- R3: Mode 010 (system management), mode 100 (non-maskable) and mode 101 with level 1 (INIT) send msgVector = 0 whatever vector was written; msgMode carries the mode code.
- R4: Bit i of msgTargets stands for processor i. The shorthand selects the targets: 00 gives only processor cmdDest, 01 gives only processor selfId, 10 gives every processor, and 11 gives every processor except selfId.
- R5: Mode 101 with level 0 and trigger 1 is sent with msgDeassert = 1, msgVector = 0 and all msgTargets bits set, ignoring cmdDest and cmdShort.
- R6: Mode 001, 011 or 111, or mode 101 with level 0 and trigger 0, sets errMode in the cycle after the write. Nothing is sent and busy stays 0.
- R7: While msgValid is 1 and msgReady is 0, msgValid, msgVector, msgTargets, msgMode and msgDeassert stay unchanged. After the handshake the block waits for rspValid before doing anything else.
- R8: A rejected message of any mode other than 110 is offered again. After RETRY_LIMIT resends (default 4, five sends in all), a further reject ends the command with failed = 1.
- R9: A rejected start-up message (mode 110) is not sent again; the command ends at once with failed = 1.
- R10: busy is 1 from the cycle after a legal write until the clock edge that takes the accepting or final rejecting response. A write while busy is dropped (the message in flight is unchanged) and sets overrun.
- R11: errMode, failed and overrun stay set until the next write taken while busy is 0, which clears them; errMode is then set again only if that write is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdWr | input | 1 | Command register write strobe |
| cmdMode | input | 3 | Delivery mode code |
| cmdVector | input | 8 | Interrupt vector |
| cmdLevel | input | 1 | Level flag |
| cmdTrigger | input | 1 | Trigger flag |
| cmdDest | input | ID_W | Destination processor ID |
| cmdShort | input | 2 | Destination shorthand |
| selfId | input | ID_W | ID of the sending processor |
| msgValid | output | 1 | Message offered on the bus |
| msgReady | input | 1 | Bus takes the message |
| msgMode | output | 3 | Delivery mode of the message |
| msgDeassert | output | 1 | Message is an INIT de-assert |
| msgVector | output | 8 | Vector slot of the message |
| msgTargets | output | NUM_CPU | Target processor mask |
| rspValid | input | 1 | Delivery response present |
| rspAccept | input | 1 | 1 = accepted, 0 = rejected |
| busy | output | 1 | Command in flight |
| errMode | output | 1 | Illegal mode written |
| failed | output | 1 | Delivery finally abandoned |
| overrun | output | 1 | Write arrived while busy |

## Verification
Every legal mode is sent with a non-zero vector written, so a zeroed slot can be told apart from a vector that was passed through. Each shorthand is used with a destination that differs from selfId, so that a wrong target choice shows up in the mask. The de-assert form is given a narrow destination and a narrow shorthand, which exposes any decoder that reads them. The response side is driven with an immediate accept, a few rejects before an accept, endless rejects, and a stalled ready. These patterns tell the retry count, the start-up exception and the handshake hold apart from each other. Illegal codes, a write while busy and a write after a failure check that nothing is sent and that the status flags set and clear as required.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMM    = 3'b010,
    DM_RSVD   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_EXT    = 3'b111
  } dlvMode_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shortHand_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } ctlState_e;

  typedef struct packed {
    logic load;
    logic tryInc;
  } ctlStrobes_t;

  function automatic logic isDeassert(input logic [2:0] mode, input logic level,
                                      input logic trigger);
    return (mode == DM_INIT) && !level && trigger;
  endfunction

  function automatic logic modeLegal(input logic [2:0] mode, input logic level,
                                     input logic trigger);
    logic ok;
    case (mode)
      DM_FIXED, DM_SMM, DM_NMI, DM_START: ok = 1'b1;
      DM_INIT:                            ok = level || trigger;
      default:                            ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [7:0] cleanVector(input logic [2:0] mode, input logic [7:0] vec);
    logic [7:0] res;
    case (mode)
      DM_FIXED, DM_START: res = vec;
      default:            res = 8'h00;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPU     = 8,
  parameter int ID_W        = $clog2(NUM_CPU),
  parameter int RETRY_LIMIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [2:0]         cmdMode,
  input  logic [7:0]         cmdVector,
  input  logic               cmdLevel,
  input  logic               cmdTrigger,
  input  logic [ID_W-1:0]    cmdDest,
  input  logic [1:0]         cmdShort,
  input  logic [ID_W-1:0]    selfId,
  output logic               cmdLegal,
  output logic               isStartup,
  output logic               tryMax,
  output logic [2:0]         msgMode,
  output logic               msgDeassert,
  output logic [7:0]         msgVector,
  output logic [NUM_CPU-1:0] msgTargets
);

  localparam int CNT_W = $clog2(RETRY_LIMIT + 1);

  logic [NUM_CPU-1:0] destHot, selfHot, allMask, tgtNext;
  logic [CNT_W-1:0]   tryCnt;
  logic               deassertNext;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_hot
    assign destHot[i] = (cmdDest == ID_W'(i));
    assign selfHot[i] = (selfId == ID_W'(i));
  end

  assign allMask      = '1;
  assign deassertNext = isDeassert(cmdMode, cmdLevel, cmdTrigger);
  assign cmdLegal     = modeLegal(cmdMode, cmdLevel, cmdTrigger);

  always_comb begin
    if (deassertNext) begin
      tgtNext = allMask;
    end else begin
      case (cmdShort)
        SH_DEST: tgtNext = destHot;
        SH_SELF: tgtNext = selfHot;
        SH_ALL:  tgtNext = allMask;
        default: tgtNext = allMask & ~selfHot;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgMode     <= 3'b000;
      msgDeassert <= 1'b0;
      msgVector   <= 8'h00;
      msgTargets  <= '0;
    end else if (strb.load) begin
      msgMode     <= cmdMode;
      msgDeassert <= deassertNext;
      msgVector   <= cleanVector(cmdMode, cmdVector);
      msgTargets  <= tgtNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tryCnt <= '0;
    end else if (strb.load) begin
      tryCnt <= '0;
    end else if (strb.tryInc) begin
      tryCnt <= tryCnt + 1'b1;
    end
  end

  assign tryMax    = (tryCnt == CNT_W'(RETRY_LIMIT));
  assign isStartup = (msgMode == DM_START);

endmodule

// File: rtl/ipi_control.sv
module ipi_control
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic        cmdLegal,
  input  logic        isStartup,
  input  logic        tryMax,
  input  logic        msgReady,
  input  logic        rspValid,
  input  logic        rspAccept,
  output ctlStrobes_t strb,
  output logic        msgValid,
  output logic        busy,
  output logic        errMode,
  output logic        failed,
  output logic        overrun
);

  ctlState_e state;
  logic      giveUp;

  assign giveUp = isStartup || tryMax;

  always_comb begin
    strb.load   = (state == ST_IDLE) && cmdWr && cmdLegal;
    strb.tryInc = (state == ST_WAIT) && rspValid && !rspAccept && !giveUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errMode <= 1'b0;
      failed  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdWr) begin
            overrun <= 1'b0;
            failed  <= 1'b0;
            errMode <= !cmdLegal;
            if (cmdLegal) state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (cmdWr) overrun <= 1'b1;
          if (msgReady) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cmdWr) overrun <= 1'b1;
          if (rspValid) begin
            if (rspAccept) begin
              state <= ST_IDLE;
            end else if (giveUp) begin
              state  <= ST_IDLE;
              failed <= 1'b1;
            end else begin
              state <= ST_SEND;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign msgValid = (state == ST_SEND);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CPU     = 8,
  parameter int ID_W        = $clog2(NUM_CPU),
  parameter int RETRY_LIMIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWr,
  input  logic [2:0]         cmdMode,
  input  logic [7:0]         cmdVector,
  input  logic               cmdLevel,
  input  logic               cmdTrigger,
  input  logic [ID_W-1:0]    cmdDest,
  input  logic [1:0]         cmdShort,
  input  logic [ID_W-1:0]    selfId,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [2:0]         msgMode,
  output logic               msgDeassert,
  output logic [7:0]         msgVector,
  output logic [NUM_CPU-1:0] msgTargets,
  input  logic               rspValid,
  input  logic               rspAccept,
  output logic               busy,
  output logic               errMode,
  output logic               failed,
  output logic               overrun
);

  ctlStrobes_t strb;
  logic        cmdLegal, isStartup, tryMax;

  ipi_datapath #(
    .NUM_CPU(NUM_CPU), .ID_W(ID_W), .RETRY_LIMIT(RETRY_LIMIT)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdMode(cmdMode), .cmdVector(cmdVector), .cmdLevel(cmdLevel),
    .cmdTrigger(cmdTrigger), .cmdDest(cmdDest), .cmdShort(cmdShort),
    .selfId(selfId), .cmdLegal(cmdLegal), .isStartup(isStartup),
    .tryMax(tryMax), .msgMode(msgMode), .msgDeassert(msgDeassert),
    .msgVector(msgVector), .msgTargets(msgTargets)
  );

  ipi_control ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdLegal(cmdLegal),
    .isStartup(isStartup), .tryMax(tryMax), .msgReady(msgReady),
    .rspValid(rspValid), .rspAccept(rspAccept), .strb(strb),
    .msgValid(msgValid), .busy(busy), .errMode(errMode),
    .failed(failed), .overrun(overrun)
  );

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int NUM_CPU = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdWr,
  input logic               msgValid,
  input logic               msgReady,
  input logic [2:0]         msgMode,
  input logic               msgDeassert,
  input logic [7:0]         msgVector,
  input logic [NUM_CPU-1:0] msgTargets,
  input logic               rspValid,
  input logic               rspAccept,
  input logic               busy,
  input logic               errMode,
  input logic               failed,
  input logic               overrun
);

  // R7
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgVector) && $stable(msgTargets)
      && $stable(msgMode) && $stable(msgDeassert));

  // R10
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> busy);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(rspValid));

  // R5
  deassert_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgDeassert |-> (&msgTargets) && msgVector == 8'h00);

  // R3
  zero_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && (msgMode == 3'b010 || msgMode == 3'b100 || msgMode == 3'b101)
      |-> msgVector == 8'h00);

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errMode) |-> !busy);

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(cmdWr && busy));

  // R8
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failed) |-> $past(rspValid && !rspAccept));

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CPU(NUM_CPU)) chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .msgValid(msgValid), .msgReady(msgReady),
  .msgMode(msgMode), .msgDeassert(msgDeassert), .msgVector(msgVector),
  .msgTargets(msgTargets), .rspValid(rspValid), .rspAccept(rspAccept),
  .busy(busy), .errMode(errMode), .failed(failed), .overrun(overrun)
);

// File: tb/ipi_dispatch_test.sv
module ipi_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU       = 8;
  localparam int IDW        = 3;
  localparam int RETRIES    = 4;

  logic clk = 0, rstN = 0;
  logic cmdWr = 0, cmdLevel = 0, cmdTrigger = 0;
  logic [2:0] cmdMode = 0;
  logic [7:0] cmdVector = 0;
  logic [IDW-1:0] cmdDest = 0, selfId = 3'd2;
  logic [1:0] cmdShort = 0;
  logic msgValid, msgReady = 0, msgDeassert, rspValid = 0, rspAccept = 0;
  logic [2:0] msgMode;
  logic [7:0] msgVector;
  logic [NCPU-1:0] msgTargets;
  logic busy, errMode, failed, overrun;

  int total = 0, bad = 0, cycles = 0, sends = 0;
  bit done = 0;

  ipi_dispatch #(.NUM_CPU(NCPU), .RETRY_LIMIT(RETRIES)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int mState = 0;           // 0 idle, 1 offering, 2 awaiting response
  int mTries = 0;
  int mMode = 0, mVec = 0, mTgt = 0, mDeas = 0;
  int mErr = 0, mFail = 0, mOvr = 0;

  function automatic int refTargets(int sh, int dest, int self);
    case (sh)
      0: return 1 << dest;
      1: return 1 << self;
      2: return 255;
      default: return 255 & ~(1 << self);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTries = 0; mMode = 0; mVec = 0; mTgt = 0; mDeas = 0;
      mErr = 0; mFail = 0; mOvr = 0;
    end else if (mState == 0) begin
      if (cmdWr) begin
        bit ok;
        bit de;
        de = (cmdMode == 5) && !cmdLevel && cmdTrigger;
        ok = (cmdMode == 0 || cmdMode == 2 || cmdMode == 4 || cmdMode == 6)
             || (cmdMode == 5 && (cmdLevel || cmdTrigger));
        mOvr = 0; mFail = 0; mErr = ok ? 0 : 1;
        if (ok) begin
          mState = 1; mTries = 0; mMode = cmdMode; mDeas = de;
          mVec = (cmdMode == 0 || cmdMode == 6) ? cmdVector : 0;
          mTgt = de ? 255 : refTargets(cmdShort, cmdDest, selfId);
        end
      end
    end else begin
      if (cmdWr) mOvr = 1;
      if (mState == 1) begin
        if (msgReady) mState = 2;
      end else if (rspValid) begin
        if (rspAccept) mState = 0;
        else if (mMode == 6 || mTries == RETRIES) begin mState = 0; mFail = 1; end
        else begin mTries++; mState = 1; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      chk("R10 busy", busy, mState != 0);
      chk("R7 msgValid", msgValid, mState == 1);
      if (mState == 1) begin
        chk("R2/R3 msgVector", msgVector, mVec);
        chk("R4/R5 msgTargets", msgTargets, mTgt);
        chk("R3 msgMode", msgMode, mMode);
        chk("R5 msgDeassert", msgDeassert, mDeas);
      end
      chk("R6 errMode", errMode, mErr);
      chk("R8/R9 failed", failed, mFail);
      chk("R10/R11 overrun", overrun, mOvr);
    end
    if (cycles > 100000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(int mode, int vec, int lvl, int trg, int dest, int sh);
    @(negedge clk);
    cmdWr = 1; cmdMode = 3'(mode); cmdVector = 8'(vec); cmdLevel = lvl[0];
    cmdTrigger = trg[0]; cmdDest = IDW'(dest); cmdShort = 2'(sh);
    @(negedge clk);
    cmdWr = 0;
  endtask

  // serve the bus: reject 'rejects' times, then accept; stall ready by 'stall'
  task automatic deliver(int rejects, int stall);
    sends = 0;
    forever begin
      while (!msgValid) @(negedge clk);
      repeat (stall) @(negedge clk);
      msgReady = 1;
      @(negedge clk);
      msgReady = 0; sends++;
      rspValid = 1; rspAccept = (sends > rejects);
      @(negedge clk);
      rspValid = 0;
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 msgValid", msgValid, 0);
    chk("R1 flags", {errMode, failed, overrun}, 0);
    rstN = 1;

    // R2 fixed to one destination (R4 shorthand 00)
    issue(0, 'h41, 0, 0, 5, 0);
    chk("R2 vector", msgVector, 'h41);
    chk("R4 dest target", msgTargets, 'h20);
    deliver(0, 0);
    chk("R10 idle after accept", busy, 0);

    // R3 system management, self shorthand
    issue(2, 'h33, 0, 0, 6, 1);
    chk("R3 smm vector", msgVector, 0);
    chk("R4 self target", msgTargets, 'h04);
    deliver(0, 0);

    // R3 non-maskable to all, R7 stalled ready
    issue(4, 'hFF, 0, 0, 1, 2);
    chk("R3 nmi vector", msgVector, 0);
    chk("R4 all target", msgTargets, 'hFF);
    deliver(0, 3);

    // R3 INIT, all but self
    issue(5, 'h77, 1, 0, 1, 3);
    chk("R3 init vector", msgVector, 0);
    chk("R4 others target", msgTargets, 'hFB);
    deliver(0, 0);

    // R5 de-assert with narrow destination and shorthand
    issue(5, 'h12, 0, 1, 3, 1);
    chk("R5 deassert flag", msgDeassert, 1);
    chk("R5 deassert target", msgTargets, 'hFF);
    chk("R5 deassert vector", msgVector, 0);
    deliver(0, 0);

    // R9 start-up rejected once: no resend
    issue(6, 'h9A, 0, 0, 7, 0);
    chk("R2 startup vector", msgVector, 'h9A);
    deliver(100, 0);
    chk("R9 startup sends", sends, 1);
    chk("R9 failed", failed, 1);

    // R11 next write clears failed
    issue(0, 'h05, 0, 0, 0, 0);
    chk("R11 failed cleared", failed, 0);
    // R8 two rejects then accept
    deliver(2, 1);
    chk("R8 sends with rejects", sends, 3);
    chk("R8 not failed", failed, 0);

    // R8 endless rejects
    issue(4, 'h10, 0, 0, 4, 0);
    deliver(100, 0);
    chk("R8 total sends", sends, RETRIES + 1);
    chk("R8 failed", failed, 1);

    // R6 illegal codes
    issue(1, 'h20, 0, 0, 0, 0);
    chk("R6 lowpri err", errMode, 1);
    chk("R6 lowpri not busy", busy, 0);
    issue(3, 'h20, 0, 0, 0, 0);
    chk("R6 reserved err", errMode, 1);
    issue(7, 'h20, 0, 0, 0, 0);
    chk("R6 code 111 err", errMode, 1);
    issue(5, 'h00, 0, 0, 0, 0);
    chk("R6 101 lvl0 trg0 err", errMode, 1);
    chk("R6 nothing sent", msgValid, 0);

    // R10 overrun: second write while offering is dropped
    issue(0, 'hC3, 0, 0, 1, 0);
    chk("R11 err cleared", errMode, 0);
    issue(6, 'h55, 0, 0, 6, 2);
    chk("R10 overrun", overrun, 1);
    chk("R10 vector kept", msgVector, 'hC3);
    chk("R10 targets kept", msgTargets, 'h02);
    deliver(0, 0);
    chk("R10 one message", sends, 1);
    issue(2, 'h00, 0, 0, 0, 2);
    chk("R11 overrun cleared", overrun, 0);
    deliver(0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule